// File: doc/BRIEF.md
# Per-Channel Output Fault Supervisor

This block sequences the protection of a bank of high-side output switches. Each channel takes three inputs: a command bit saying the load should be on, an overcurrent comparator flag and an overtemperature flag. From these it decides, clock by clock, whether the channel's gate may be driven. It also decides whether the current limiter is engaged and which of two limit levels the limiter applies. A shared undervoltage supervisor watches two supply flags, one for the low trip threshold and one for the higher release threshold. While the supply is low, it holds every channel off.

Each channel runs its own state machine and reacts only to its own flags. The first overcurrent event after a command-on engages the high peak limit for one cycle. The channel then drops to a lower repetitive limit, and that lower level stays selected until the command is removed. A thermal trip switches the gate off and restarts the channel as soon as the flag clears, so a persistent fault produces a low-duty on/off pattern. After an undervoltage lockout ends, every commanded channel restarts without software help.

Top module: `fault_supervisor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every `gate_en`, `lim_en` and `lim_low` bit is 0 and the undervoltage lock is released.
- R2: A channel whose command is 1, with no fault flag and no lock, drives `gate_en` to 1 one clock after the command is sampled, with `lim_en` 0.
- R3: The first overcurrent sample on a running channel whose tier is peak sets `lim_en` to 1 with `lim_low` 0 (peak level) one clock later. One clock after that, `lim_low` becomes 1 (repetitive level), whatever the flag is then.
- R4: A channel in repetitive limiting returns to normal running (`lim_en` 0, `gate_en` 1) after CLEAR_CYCLES consecutive clock samples with its overcurrent flag 0. Any overcurrent sample restarts this count.
- R5: An overtemperature sample on a commanded channel forces `gate_en` and `lim_en` to 0 one clock later, including at turn-on and during current limiting. The first sample with the flag clear restarts the channel one clock later, with its limit tier unchanged.
- R6: A command of 0 forces `gate_en`, `lim_en` and `lim_low` of that channel to 0 one clock later, from any state. This resets the channel's tier to peak.
- R7: A `uv_trip` sample sets the lock, and all gates are 0 two clocks after that sample. The lock clears only on a sample with `uv_rel` 1 and `uv_trip` 0, and `uv_trip` wins when both are 1. Commanded channels restart one clock after the lock clears, with their tiers kept.
- R8: Flags on one channel never change the outputs of any other channel.
- R9: Once a channel's tier is repetitive, a later overcurrent sample takes it straight to limiting at the lower level (`lim_en` 1, `lim_low` 1) one clock later, with no peak phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_on | input | NCH | Per-channel command: 1 asks for the load on |
| oc_flag | input | NCH | Per-channel overcurrent comparator flag |
| ot_flag | input | NCH | Per-channel overtemperature flag |
| uv_trip | input | 1 | Supply below the low (trip) threshold |
| uv_rel | input | 1 | Supply above the high (release) threshold |
| gate_en | output | NCH | Per-channel gate drive enable |
| lim_en | output | NCH | Per-channel current limiter engaged |
| lim_low | output | NCH | Per-channel limit level: 0 peak, 1 repetitive |

## Verification
The bench builds the block with NCH=4 and CLEAR_CYCLES=3. With these values, the full fault sequence can be run on each channel in turn while the other three stay steady, which exposes any crosstalk between channels. With a clear window of three, every gap length from zero to CLEAR_CYCLES-1 before a repeated overcurrent can be swept. This shows the clear count restarting at each length and the return to running landing on exactly the expected clock.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [2:0] {
    CH_OFF  = 3'd0,
    CH_RUN  = 3'd1,
    CH_PEAK = 3'd2,
    CH_REP  = 3'd3,
    CH_HOT  = 3'd4
  } ch_state_e;

  function automatic logic drives_gate(input ch_state_e s);
    return (s == CH_RUN) || (s == CH_PEAK) || (s == CH_REP);
  endfunction

  function automatic logic limiting(input ch_state_e s);
    return (s == CH_PEAK) || (s == CH_REP);
  endfunction
endpackage

// File: rtl/fs_uv_lockout.sv
module fs_uv_lockout (
  input  logic clk,
  input  logic rst,
  input  logic uv_trip,
  input  logic uv_rel,
  output logic uv_lock
);
  always_ff @(posedge clk) begin
    if (rst) begin
      uv_lock <= 1'b0;
    end else if (uv_trip) begin
      uv_lock <= 1'b1;
    end else if (uv_rel) begin
      uv_lock <= 1'b0;
    end
  end

  // R7: trip sample always locks
  p_trip_locks_r7: assert property (@(posedge clk) disable iff (rst)
    uv_trip |=> uv_lock);
  // R7: release without trip unlocks
  p_release_unlocks_r7: assert property (@(posedge clk) disable iff (rst)
    (uv_rel && !uv_trip) |=> !uv_lock);
  // R7: with neither flag the lock holds (hysteresis band)
  p_hold_band_r7: assert property (@(posedge clk) disable iff (rst)
    (!uv_rel && !uv_trip) |=> $stable(uv_lock));
endmodule

// File: rtl/fs_clear_timer.sv
module fs_clear_timer #(
  parameter int CLEAR_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic oc,
  output logic done
);
  localparam int CW = (CLEAR_CYCLES > 1) ? $clog2(CLEAR_CYCLES + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLEAR_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = active && !oc && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !active || oc) begin
      cnt <= '0;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4: the clear count never runs past its window
  p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  // R4: an overcurrent sample restarts the count
  p_oc_restarts_r4: assert property (@(posedge clk) disable iff (rst)
    oc |=> (cnt == '0));
endmodule

// File: rtl/fs_channel.sv
module fs_channel
  import fs_pkg::*;
#(
  parameter int CLEAR_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_on,
  input  logic oc,
  input  logic ot,
  input  logic uv_lock,
  output logic gate_en,
  output logic lim_en,
  output logic lim_low
);
  ch_state_e state, nxt;
  logic      tier, nxt_tier;
  logic      clear_done;

  fs_clear_timer #(.CLEAR_CYCLES(CLEAR_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .active (state == CH_REP),
    .oc     (oc),
    .done   (clear_done)
  );

  always_comb begin
    nxt      = state;
    nxt_tier = tier;
    if (!cmd_on) begin
      nxt      = CH_OFF;
      nxt_tier = 1'b0;
    end else if (uv_lock) begin
      nxt = CH_OFF;
    end else begin
      unique case (state)
        CH_OFF:  nxt = ot ? CH_HOT : CH_RUN;
        CH_RUN: begin
          if (ot)      nxt = CH_HOT;
          else if (oc) nxt = tier ? CH_REP : CH_PEAK;
        end
        CH_PEAK: begin
          if (ot) begin
            nxt = CH_HOT;
          end else begin
            nxt      = CH_REP;
            nxt_tier = 1'b1;
          end
        end
        CH_REP: begin
          if (ot)              nxt = CH_HOT;
          else if (clear_done) nxt = CH_RUN;
        end
        CH_HOT:  if (!ot) nxt = CH_RUN;
        default: nxt = CH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= CH_OFF;
      tier    <= 1'b0;
      gate_en <= 1'b0;
      lim_en  <= 1'b0;
      lim_low <= 1'b0;
    end else begin
      state   <= nxt;
      tier    <= nxt_tier;
      gate_en <= drives_gate(nxt);
      lim_en  <= limiting(nxt);
      lim_low <= nxt_tier;
    end
  end

  // R6: command off clears the channel
  p_cmd_off_r6: assert property (@(posedge clk) disable iff (rst)
    !cmd_on |=> (!gate_en && !lim_en && !lim_low));
  // R5: a hot sample never leaves the gate on
  p_hot_off_r5: assert property (@(posedge clk) disable iff (rst)
    ot |=> !gate_en);
  // R7: lockout keeps the gate off
  p_lock_off_r7: assert property (@(posedge clk) disable iff (rst)
    uv_lock |=> !gate_en);
  // R9: the repetitive tier sticks while commanded
  p_tier_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (lim_low && cmd_on) |=> lim_low);
  // R3: limiter only engages with the gate driven
  p_lim_needs_gate_r3: assert property (@(posedge clk) disable iff (rst)
    lim_en |-> gate_en);
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int NCH          = 8,
  parameter int CLEAR_CYCLES = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] cmd_on,
  input  logic [NCH-1:0] oc_flag,
  input  logic [NCH-1:0] ot_flag,
  input  logic           uv_trip,
  input  logic           uv_rel,
  output logic [NCH-1:0] gate_en,
  output logic [NCH-1:0] lim_en,
  output logic [NCH-1:0] lim_low
);
  logic uv_lock;

  fs_uv_lockout u_uv (
    .clk     (clk),
    .rst     (rst),
    .uv_trip (uv_trip),
    .uv_rel  (uv_rel),
    .uv_lock (uv_lock)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    fs_channel #(.CLEAR_CYCLES(CLEAR_CYCLES)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .cmd_on  (cmd_on[i]),
      .oc      (oc_flag[i]),
      .ot      (ot_flag[i]),
      .uv_lock (uv_lock),
      .gate_en (gate_en[i]),
      .lim_en  (lim_en[i]),
      .lim_low (lim_low[i])
    );
  end

  // R7: two clocks after a trip sample every gate is off
  p_trip_all_off_r7: assert property (@(posedge clk) disable iff (rst)
    uv_lock |=> (gate_en == '0));
endmodule

// File: tb/fault_supervisor_bench.sv
`timescale 1ns/1ps
module fault_supervisor_bench;
  localparam int N   = 4;
  localparam int CLR = 3;
  localparam logic [N-1:0] ALL = '1;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] cmd, oc, ot;
  logic         uvt, uvr;
  logic [N-1:0] g, le, ll;

  int checks = 0;
  int bad    = 0;

  always #2.5 clk = ~clk;

  fault_supervisor #(.NCH(N), .CLEAR_CYCLES(CLR)) u_fault_supervisor (
    .clk(clk), .rst(rst), .cmd_on(cmd), .oc_flag(oc), .ot_flag(ot),
    .uv_trip(uvt), .uv_rel(uvr), .gate_en(g), .lim_en(le), .lim_low(ll)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic expect3(input string tag, input logic [N-1:0] eg,
                         input logic [N-1:0] ele, input logic [N-1:0] ell);
    check(tag, "gate_en", g, eg);
    check(tag, "lim_en", le, ele);
    check(tag, "lim_low", ll, ell);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cmd = ALL; oc = '0; ot = '0; uvt = 1'b0; uvr = 1'b0;
    repeat (3) step();
    expect3("R1", '0, '0, '0);
    cmd = '0;
    rst = 1'b0;
    step();
    expect3("R1", '0, '0, '0);

    for (int c = 0; c < N; c++) begin
      logic [N-1:0] m;
      m = N'(1) << c;
      cmd = '0; oc = '0; ot = '0;
      step(); expect3("R6", '0, '0, '0);
      cmd = ALL;
      step(); expect3("R2", ALL, '0, '0);
      // peak phase then repetitive tier
      oc = m;
      step(); expect3("R3", ALL, m, '0);
      step(); expect3("R3", ALL, m, m);
      oc = '0;
      for (int k = 0; k < CLR - 1; k++) begin
        step(); expect3("R4", ALL, m, m);
      end
      step(); expect3("R4", ALL, '0, m);
      // gap sweep: an overcurrent after g clear samples restarts the window
      for (int gap = 0; gap < CLR; gap++) begin
        oc = m;
        step(); expect3("R9", ALL, m, m);
        oc = '0;
        for (int k = 0; k < gap; k++) begin
          step(); expect3("R4", ALL, m, m);
        end
        oc = m;
        step(); expect3("R4", ALL, m, m);
        oc = '0;
        for (int k = 0; k < CLR - 1; k++) begin
          step(); expect3("R4", ALL, m, m);
        end
        step(); expect3("R4", ALL, '0, m);
      end
      // thermal trip while running, others untouched
      ot = m;
      step(); expect3("R5", ALL & ~m, '0, m);
      step(); expect3("R8", ALL & ~m, '0, m);
      ot = '0;
      step(); expect3("R5", ALL, '0, m);
      // thermal trip during limiting
      oc = m;
      step(); expect3("R5", ALL, m, m);
      ot = m;
      step(); expect3("R5", ALL & ~m, '0, m);
      ot = '0; oc = '0;
      step(); expect3("R5", ALL, '0, m);
      // command off resets tier
      cmd = ALL & ~m;
      step(); expect3("R6", ALL & ~m, '0, '0);
      // thermal at turn-on
      cmd = ALL; ot = m;
      step(); expect3("R5", ALL & ~m, '0, '0);
      ot = '0;
      step(); expect3("R5", ALL, '0, '0);
      // peak phase proceeds to repetitive even if the flag has cleared
      oc = m;
      step(); expect3("R3", ALL, m, '0);
      oc = '0;
      step(); expect3("R3", ALL, m, m);
      repeat (CLR) step();
      expect3("R4", ALL, '0, m);
    end

    // undervoltage lockout with hysteresis; channel 3 holds repetitive tier
    uvt = 1'b1;
    step(); expect3("R7", ALL, '0, 4'b1000);
    step(); expect3("R7", '0, '0, 4'b1000);
    uvt = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step(); expect3("R7", '0, '0, 4'b1000);
    end
    uvt = 1'b1; uvr = 1'b1;
    step(); step(); expect3("R7", '0, '0, 4'b1000);
    uvt = 1'b0;
    step(); expect3("R7", '0, '0, 4'b1000);
    uvr = 1'b0;
    step(); expect3("R7", ALL, '0, 4'b1000);
    repeat (2) step();
    expect3("R7", ALL, '0, 4'b1000);

    rst = 1'b1;
    step(); expect3("R1", '0, '0, '0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule